// File: doc/BRIEF.md
# Triggered Serial Capture and Replay Engine

This block takes one of sixteen logic inputs and records it, one bit per sample strobe, into a circular shift store that is 128 stages deep. A capture starts when an operator presses the capture button or when an external trigger pulse arrives. After the capture, the operator can start a replay with the display button. On each slow display tick the oldest stored bit moves into a sixteen-position display chain, and the chain shifts like a serial-in, parallel-out register. The same bit is also written back into the store, so a complete replay leaves the store contents unchanged and the data can be shown again.

One 128-count position counter serves both capture and replay. When the counter wraps, the active phase ends. A capture started by the button clears the counter first. A capture started by the trigger does not clear it, so further trigger pulses cannot restart a capture that is already running. A replay that was paused keeps its place. Everything runs on one clock. The sample strobe and the display tick come in as single-cycle enables, and the button and trigger inputs are single-cycle pulses that have already been debounced.

Top module: `serial_capture_replay`

## Requirements
- R1: A pulse on `cap_btn` or `ext_trig` while no replay is running makes `capturing` high from the next cycle onward.
- R2: While capturing, each `smp_en` pulse shifts the selected input bit into the store and advances the position counter. The 128th such shift ends the capture and clears the counter, so `capturing` is low in the following cycle.
- R3: `cap_btn` clears the position counter, so a capture restarted by the button needs a full 128 further samples before it ends. `ext_trig` leaves the counter as it is. A capture started by the trigger after a replay was paused at position k therefore ends after 128-k samples, and extra trigger pulses during a capture do not extend it.
- R4: `disp` is all zeros whenever `capturing` is high.
- R5: During a replay, each `tick` shifts the display chain up by one. Position 0 receives the oldest stored bit, and that bit goes back into the store. The stored sequence is not changed, so the next replay shows the same bits again.
- R6: The 128th tick of a replay clears the counter, and `replaying` goes low in the next cycle.
- R7: `disp_btn` toggles `replaying`. A pause keeps both the counter and the display chain, so resuming continues with the next stored bit.
- R8: `disp[k]` shows chain position k. Position 0, bit 0, is the lamp for input 1. Positions 0 to 7 run down the left bank and positions 8 to 15 run up the right bank. When the block is neither capturing nor replaying, `disp` follows `din` directly.
- R9: Capture requests that arrive during a replay are ignored, and so is `disp_btn` during a capture. `capturing` and `replaying` are never high together.
- R10: `sel` is one-hot, and bit i picks `din[i]`. If no bit of `sel` is set, the captured bit is 0.
- R11: After reset, both flags are low, the counter is zero, and the store and the display chain are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Live logic inputs; bit i is input i+1 |
| sel | input | 16 | One-hot choice of the captured input |
| cap_btn | input | 1 | Capture button pulse, clears the counter |
| ext_trig | input | 1 | External capture trigger pulse |
| disp_btn | input | 1 | Replay on/off toggle pulse |
| smp_en | input | 1 | Sample strobe derived from the external clock |
| tick | input | 1 | Display advance enable |
| disp | output | 16 | Lamp drive: live inputs, replay chain, or blank |
| capturing | output | 1 | Capture phase active |
| replaying | output | 1 | Replay phase active |

## Verification
If the position counter is wrong, the symptom appears at an end-of-phase boundary. `capturing` or `replaying` falls one or more strobes early or late, and the trigger-resume case shows this most clearly because the end point depends on where the previous replay stopped. If the recirculation path is wrong, the first full replay still looks correct, but the second replay differs on its first tick. A wrong store order or wrong chain direction appears on `disp` at the very first tick, because the oldest bit has to land on bit 0. A blanking or mux fault shows on `disp` in the cycle after the request.

// File: rtl/scr_pkg.sv
package scr_pkg;

    // Operation applied to the circular store in a given cycle.
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_RECIRC = 2'd2
    } store_op_e;

    // Phase flags of the sequencer.
    typedef struct packed {
        logic cap;
        logic rep;
    } phase_t;

    // Which source drives the lamp outputs.
    typedef enum logic [1:0] {
        VIEW_LIVE  = 2'd0,
        VIEW_CHAIN = 2'd1,
        VIEW_BLANK = 2'd2
    } view_e;

    function automatic view_e pick_view(input phase_t ph);
        if (ph.cap)      return VIEW_BLANK;
        else if (ph.rep) return VIEW_CHAIN;
        else             return VIEW_LIVE;
    endfunction

endpackage

// File: rtl/scr_lane_pick.sv
module scr_lane_pick #(
    parameter int unsigned LANES = 16
) (
    input  logic [LANES-1:0] din,
    input  logic [LANES-1:0] sel,
    output logic             bit_o
);
    logic [LANES-1:0] hit;

    // AND-OR selection: with no select bit set, every term is zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g] = din[g] & sel[g];
    end

    assign bit_o = |hit;
endmodule

// File: rtl/scr_sequencer.sv
module scr_sequencer
    import scr_pkg::*;
#(
    parameter int unsigned DEPTH = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cap_btn,
    input  logic      ext_trig,
    input  logic      disp_btn,
    input  logic      smp_en,
    input  logic      tick,
    output store_op_e op,
    output phase_t    phase
);
    localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST_POS = CW'(DEPTH - 1);

    phase_t        ph_q;
    logic [CW-1:0] pos_q;

    logic cap_req_ok;
    logic cap_shift;
    logic rep_shift;
    logic at_last;
    logic toggle_ok;

    assign cap_req_ok = (cap_btn | ext_trig) & ~ph_q.rep;
    assign cap_shift  = ph_q.cap & smp_en;
    assign rep_shift  = ph_q.rep & tick;
    assign at_last    = (pos_q == LAST_POS);
    assign toggle_ok  = disp_btn & ~ph_q.cap & ~cap_req_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            pos_q <= '0;
        end else begin
            // capture flag: set on an accepted request, cleared at wrap
            if (cap_shift && at_last && !cap_btn)
                ph_q.cap <= 1'b0;
            else if (cap_req_ok)
                ph_q.cap <= 1'b1;

            // replay flag: toggled by the display button, cleared at wrap
            if (rep_shift && at_last)
                ph_q.rep <= 1'b0;
            else if (toggle_ok)
                ph_q.rep <= ~ph_q.rep;

            // one shared position counter for both phases
            if (cap_btn && !ph_q.rep)
                pos_q <= '0;
            else if (cap_shift || rep_shift)
                pos_q <= at_last ? '0 : pos_q + 1'b1;
        end
    end

    always_comb begin
        if (cap_shift)      op = ST_LOAD;
        else if (rep_shift) op = ST_RECIRC;
        else                op = ST_HOLD;
    end

    assign phase = ph_q;

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ph_q.cap && ph_q.rep));

    a_r2_capture_wrap: assert property (@(posedge clk) disable iff (rst)
        (cap_shift && at_last && !cap_btn) |=> (!ph_q.cap && pos_q == '0));

    a_r3_trigger_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (ph_q.cap && ext_trig && !cap_btn && !smp_en) |=> $stable(pos_q));

    a_r6_replay_wrap: assert property (@(posedge clk) disable iff (rst)
        (rep_shift && at_last) |=> (!ph_q.rep && pos_q == '0));

    a_r7_pause_holds: assert property (@(posedge clk) disable iff (rst)
        (!ph_q.rep && !ph_q.cap && !cap_btn) |=> $stable(pos_q));

    a_r9_no_capture_in_replay: assert property (@(posedge clk) disable iff (rst)
        (ph_q.rep && !(rep_shift && at_last)) |=> !ph_q.cap);
endmodule

// File: rtl/scr_store.sv
module scr_store
    import scr_pkg::*;
#(
    parameter int unsigned DEPTH = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  store_op_e op,
    input  logic      bit_in,
    output logic      head
);
    logic [DEPTH-1:0] sh_q;
    logic             feed;

    // new sample on capture, oldest bit fed back on replay
    always_comb begin
        unique case (op)
            ST_LOAD:   feed = bit_in;
            ST_RECIRC: feed = sh_q[DEPTH-1];
            default:   feed = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (op != ST_HOLD)
            sh_q <= {sh_q[DEPTH-2:0], feed};
    end

    assign head = sh_q[DEPTH-1];

    a_r2_load_enters: assert property (@(posedge clk) disable iff (rst)
        (op == ST_LOAD) |=> (sh_q[0] == $past(bit_in)));

    a_r5_recirculates: assert property (@(posedge clk) disable iff (rst)
        (op == ST_RECIRC) |=> (sh_q[0] == $past(sh_q[DEPTH-1])));

    a_r7_store_holds: assert property (@(posedge clk) disable iff (rst)
        (op == ST_HOLD) |=> $stable(sh_q));
endmodule

// File: rtl/scr_display.sv
module scr_display
    import scr_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             head,
    input  phase_t           phase,
    input  logic [LANES-1:0] live,
    output logic [LANES-1:0] disp
);
    logic [LANES-1:0] chain_q;
    view_e            view;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else if (shift)
            chain_q <= {chain_q[LANES-2:0], head};
    end

    assign view = pick_view(phase);

    always_comb begin
        unique case (view)
            VIEW_BLANK: disp = '0;
            VIEW_CHAIN: disp = chain_q;
            default:    disp = live;
        endcase
    end

    a_r5_chain_entry: assert property (@(posedge clk) disable iff (rst)
        shift |=> (chain_q[0] == $past(head)));

    a_r7_chain_holds: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(chain_q));
endmodule

// File: rtl/serial_capture_replay.sv
module serial_capture_replay
    import scr_pkg::*;
#(
    parameter int unsigned LANES = 16,
    parameter int unsigned DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] din,
    input  logic [LANES-1:0] sel,
    input  logic             cap_btn,
    input  logic             ext_trig,
    input  logic             disp_btn,
    input  logic             smp_en,
    input  logic             tick,
    output logic [LANES-1:0] disp,
    output logic             capturing,
    output logic             replaying
);
    store_op_e op;
    phase_t    phase;
    logic      pick_bit;
    logic      head;

    scr_lane_pick #(.LANES(LANES)) u_pick (
        .din   (din),
        .sel   (sel),
        .bit_o (pick_bit)
    );

    scr_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cap_btn  (cap_btn),
        .ext_trig (ext_trig),
        .disp_btn (disp_btn),
        .smp_en   (smp_en),
        .tick     (tick),
        .op       (op),
        .phase    (phase)
    );

    scr_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .bit_in (pick_bit),
        .head   (head)
    );

    scr_display #(.LANES(LANES)) u_disp (
        .clk   (clk),
        .rst   (rst),
        .shift (op == ST_RECIRC),
        .head  (head),
        .phase (phase),
        .live  (din),
        .disp  (disp)
    );

    assign capturing = phase.cap;
    assign replaying = phase.rep;

    a_r4_blank: assert property (@(posedge clk) disable iff (rst)
        capturing |-> (disp == '0));

    a_r1_request_starts: assert property (@(posedge clk) disable iff (rst)
        ((cap_btn || ext_trig) && !replaying) |=> capturing);
endmodule

// File: tb/sim_serial_capture_replay.sv
module sim_serial_capture_replay;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] sel = '0;
    logic        cap_btn = 1'b0, ext_trig = 1'b0, disp_btn = 1'b0;
    logic        smp_en = 1'b0, tick = 1'b0;
    logic [15:0] disp;
    logic        capturing, replaying;

    int checks = 0;
    int errors = 0;
    logic [15:0] ch = '0;     // model of the display chain
    bit seq [128];            // expected replay order, oldest first

    always #4 clk = ~clk;

    serial_capture_replay u0 (
        .clk(clk), .rst(rst), .din(din), .sel(sel),
        .cap_btn(cap_btn), .ext_trig(ext_trig), .disp_btn(disp_btn),
        .smp_en(smp_en), .tick(tick),
        .disp(disp), .capturing(capturing), .replaying(replaying)
    );

    function automatic bit pat_p(int k);
        return ((k * 5 + 3) % 7) < 3;
    endfunction

    function automatic bit pat_q(int k);
        return ((k % 3) == 0) ^ (k > 60);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive single-cycle pulses from a falling edge; return at the next one.
    task automatic drive(bit cb, bit et, bit db, bit se, bit tk);
        cap_btn = cb; ext_trig = et; disp_btn = db; smp_en = se; tick = tk;
        @(negedge clk);
        cap_btn = 0; ext_trig = 0; disp_btn = 0; smp_en = 0; tick = 0;
    endtask

    task automatic sample(bit b);
        din = {16{~b}} ^ sel;
        drive(0, 0, 0, 1, 0);
    endtask

    task automatic tick_check(bit o, string req);
        drive(0, 0, 0, 0, 1);
        ch = {ch[14:0], o};
        if (replaying) check(req, disp, ch);
    endtask

    task automatic t_reset();
        din = 16'hA5C3;
        @(negedge clk);
        check("R11 capturing", {15'b0, capturing}, 16'h0);
        check("R11 replaying", {15'b0, replaying}, 16'h0);
        check("R8 idle live view", disp, 16'hA5C3);
    endtask

    task automatic t_capture_button();
        sel = 16'h0010;
        drive(1, 0, 0, 0, 0);
        check("R1 button start", {15'b0, capturing}, 16'h1);
        check("R4 blank", disp, 16'h0);
        for (int k = 0; k < 128; k++) begin
            sample(pat_p(k));
            seq[k] = pat_p(k);
            if (k == 63)  check("R4 blank mid", disp, 16'h0);
            if (k == 126) check("R2 still capturing", {15'b0, capturing}, 16'h1);
        end
        check("R2 ends at 128", {15'b0, capturing}, 16'h0);
    endtask

    task automatic t_replay_pause();
        ch = '0;
        drive(0, 0, 1, 0, 0);
        check("R7 replay on", {15'b0, replaying}, 16'h1);
        for (int n = 0; n < 20; n++) tick_check(seq[n], "R5 R8 replay");
        drive(0, 0, 1, 0, 0);
        check("R7 paused", {15'b0, replaying}, 16'h0);
        din = 16'h3C5A;
        @(negedge clk);
        check("R8 live when paused", disp, 16'h3C5A);
        drive(0, 0, 1, 0, 0);
        check("R7 chain kept", disp, ch);
        for (int n = 20; n < 128; n++) begin
            tick_check(seq[n], "R7 resume");
            if (n == 126) check("R6 still replaying", {15'b0, replaying}, 16'h1);
        end
        check("R6 replay ends", {15'b0, replaying}, 16'h0);
    endtask

    task automatic t_ignore_in_replay();
        drive(0, 0, 1, 0, 0);
        drive(1, 0, 0, 0, 0);
        check("R9 button ignored", {15'b0, capturing}, 16'h0);
        drive(0, 1, 0, 0, 0);
        check("R9 trigger ignored", {15'b0, capturing}, 16'h0);
        check("R9 display intact", disp, ch);
        for (int n = 0; n < 128; n++) tick_check(seq[n], "R5 second pass");
        check("R6 second end", {15'b0, replaying}, 16'h0);
    endtask

    task automatic t_trigger_resume();
        drive(0, 0, 1, 0, 0);
        for (int n = 0; n < 10; n++) tick_check(seq[n], "R5 partial");
        drive(0, 0, 1, 0, 0);
        sel = 16'h0100;
        drive(0, 1, 0, 0, 0);
        check("R1 trigger start", {15'b0, capturing}, 16'h1);
        for (int k = 0; k < 118; k++) begin
            if (k == 60) drive(0, 1, 0, 0, 0);
            sample(pat_q(k));
            if (k == 116) check("R3 trigger no reset pre", {15'b0, capturing}, 16'h1);
        end
        check("R3 trigger ends at 128-k", {15'b0, capturing}, 16'h0);
        for (int k = 0; k < 118; k++) seq[10 + k] = pat_q(k);
        drive(0, 0, 1, 0, 0);
        for (int n = 0; n < 128; n++) tick_check(seq[n], "R3 mixed order");
        check("R6 end after mixed", {15'b0, replaying}, 16'h0);
    endtask

    task automatic t_restart_nosel();
        sel = 16'h0000;
        drive(1, 0, 0, 0, 0);
        for (int k = 0; k < 50; k++) sample(pat_p(k));
        drive(1, 0, 0, 0, 0);
        for (int k = 0; k < 127; k++) sample(pat_p(k));
        check("R3 button restart", {15'b0, capturing}, 16'h1);
        sample(1'b1);
        check("R3 restart ends", {15'b0, capturing}, 16'h0);
        drive(0, 0, 1, 0, 0);
        for (int n = 0; n < 16; n++) tick_check(1'b0, "R10 no select gives 0");
        check("R10 chain zero", disp, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_capture_button();
        t_replay_pause();
        t_ignore_in_replay();
        t_trigger_resume();
        t_restart_nosel();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule